// File: doc/BRIEF.md
# TDM Audio Serial Transmitter

This block drives one serial audio data pin and its frame sync in time-division-multiplexed form. Software programs a small register set: the slot width, a nibble-step right rotation, a 32-bit keep mask with a selectable pad value, the bit order, the number of slots per frame, the frame-sync width, polarity and data delay, and a per-slot enable mask. It then releases the clock, the serializer, the sequencer and the frame-sync generator one after another. Sample words are written one at a time into a single transmit buffer. Every enabled slot takes one word from that buffer, formats it and shifts it out. Disabled slots drive the pin low.

The bit timing comes either from an external bit clock, synchronised into the system clock with a selectable active edge, or from an internal divider of the system clock. Every output change happens on one system-clock edge, called a step strobe. If an enabled slot starts while the buffer is empty, the slot is sent as zeros and a sticky underrun flag is raised.

Top module: `tdm_tx`

## Requirements
- R1: The slot width comes from format bits 7:4. Odd codes give (code+1)*2 bits (0x3 gives 8, 0xB gives 24, 0xF gives 32). An even code gives the width of code+1. Codes 0 to 2 give 8 bits.
- R2: Before shifting, each word is rotated right by 4 times format bits 2:0 (a value of 6 gives 24 bits, a value of 0 gives no rotation).
- R3: After rotation, every bit whose mask bit is 0 is replaced by the pad value chosen by format bits 14:13. Code 0 pads with 0 and code 1 pads with 1. Codes 2 and 3 pad with the rotated word's bit at the index held in format bits 12:8.
- R4: Format bit 15 set sends the slot's bits MSB first, from bit width-1 down to bit 0. Clear sends them LSB first.
- R5: The frame has as many slots as frame-control bits 15:7 give, with values below 2 taken as 2 and above 32 taken as 32. The frame sync is active on the first bit of slot 0 only when frame-control bit 4 is 0, and for the whole of slot 0 when it is 1. Frame-control bit 0 set makes the active level low.
- R6: Data lags the frame sync by format bits 17:16 bit periods (0, 1 or 2; code 3 acts as 2). Bit periods before the first data bit are sent as 0.
- R7: Slot-enable bit n set makes slot n take one word from the buffer. A disabled slot takes no word and drives the pin low.
- R8: With clock-control bit 5 set, one bit period lasts (bits 4:0 + 1) system clocks. With it clear, bits advance on the external bit clock: on its rising edge if clock-control bit 7 is 0, on its falling edge if it is 1.
- R9: Global-control bits 8, 10, 11 and 12 release the bit clock, the serializer, the sequencer and the frame-sync generator; bit 9 is a stored stage bit. While bit 10 is 0 the pin is low and the buffer counts as empty. While bit 11 or bit 12 is 0 the frame sync sits at its inactive level. Writing 0 stops all of it. A global-control read returns the released bits one clock after the write takes effect.
- R10: Status bit 4 reads 1 when the serializer is released and the buffer is empty. Status bit 0 is a sticky underrun flag: it is set when an enabled slot starts on an empty buffer (that slot is sent as zeros) and cleared by writing 1 to status bit 0.
- R11: With frame-control bit 1 clear, the frame-sync output is held low.
- R12: The register word addresses are global control 0, format 1, frame control 2, clock control 3, keep mask 4, slot enable 5, transmit buffer 6 and status 7. Format, frame and clock registers read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| ext_bclk | input | 1 | External bit clock |
| ser_o | output | 1 | Serial data pin |
| fs_o | output | 1 | Frame sync pin |

## Verification
An external bit-clock transition passes two synchroniser flops and an edge detector, so the pin outputs change on the third system-clock edge after it. The bench holds each half period for six clocks and samples both pins just before the next transition. In divider mode the frame-sync high time and period are counted in system clocks and must equal one and sixteen bit periods of (div+1) clocks. A buffer write turns the ready flag off on the next edge, and a global-control write shows in the readback one edge after that. Reads are therefore made at least two falling edges after a write.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned POS_W  = 6;

  typedef struct packed {
    logic [POS_W-1:0] bitc;
    logic [POS_W-1:0] slot;
  } pos_t;

  // slot width in bits from the 4-bit size code
  function automatic logic [POS_W-1:0] slot_bits(input logic [3:0] code);
    logic [POS_W-1:0] w;
    if (code < 4'd3) return POS_W'(8);
    w = {3'b000, code[3:1]} + POS_W'(1);
    return w << 2;
  endfunction

  // frame slot count, held to 2..32
  function automatic logic [POS_W-1:0] clamp_slots(input logic [8:0] f);
    if (f < 9'd2)  return POS_W'(2);
    if (f > 9'd32) return POS_W'(32);
    return f[POS_W-1:0];
  endfunction

  function automatic logic [WORD_W-1:0] rotr4(input logic [WORD_W-1:0] w,
                                             input logic [2:0] r);
    logic [2*WORD_W-1:0] d;
    d = {w, w} >> {r, 2'b00};
    return d[WORD_W-1:0];
  endfunction

  function automatic logic [WORD_W-1:0] fmt_word(input logic [WORD_W-1:0] w,
                                                input logic [2:0] rot,
                                                input logic [WORD_W-1:0] keep,
                                                input logic [1:0] pad,
                                                input logic [4:0] pidx);
    logic [WORD_W-1:0] r;
    logic pb;
    r  = rotr4(w, rot);
    pb = pad[1] ? r[pidx] : pad[0];
    return (r & keep) | (~keep & {WORD_W{pb}});
  endfunction

  function automatic logic pick_bit(input logic [WORD_W-1:0] w,
                                    input logic [POS_W-1:0] sb,
                                    input logic [POS_W-1:0] b,
                                    input logic msb);
    logic [POS_W-1:0] idx;
    idx = msb ? (sb - POS_W'(1) - b) : b;
    return w[idx[4:0]];
  endfunction

  function automatic pos_t adv(input pos_t p, input logic [POS_W-1:0] sb,
                               input logic [POS_W-1:0] ns);
    pos_t n;
    n = p;
    if (p.bitc + POS_W'(1) >= sb) begin
      n.bitc = '0;
      n.slot = (p.slot + POS_W'(1) >= ns) ? '0 : p.slot + POS_W'(1);
    end else begin
      n.bitc = p.bitc + POS_W'(1);
    end
    return n;
  endfunction

endpackage

// File: rtl/tdm_tx_regs.sv
module tdm_tx_regs
  import tdm_tx_pkg::*;
#(
  parameter int unsigned DIV_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [2:0]        addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic [2:0]        f_rot,
  output logic [3:0]        f_ssz,
  output logic [4:0]        f_pidx,
  output logic [1:0]        f_pad,
  output logic              f_msb,
  output logic [1:0]        f_dly,
  output logic              fr_pol,
  output logic              fr_int,
  output logic              fr_wide,
  output logic [8:0]        fr_nslot,
  output logic [DIV_W-1:0]  ck_div,
  output logic              ck_int,
  output logic              ck_fall,
  output logic [WORD_W-1:0] keep,
  output logic [WORD_W-1:0] slot_en,
  output logic              g_bclk,
  output logic              g_ser,
  output logic              g_sm,
  output logic              g_fsg,
  output logic              buf_wr,
  output logic              undr_clr,
  input  logic              ready,
  input  logic              undr,
  input  logic [WORD_W-1:0] buf_q
);
  localparam logic [2:0] A_GCTL = 3'd0, A_FMT = 3'd1, A_FRM = 3'd2, A_CLK = 3'd3;
  localparam logic [2:0] A_KEEP = 3'd4, A_SLOT = 3'd5, A_BUF = 3'd6, A_STAT = 3'd7;

  logic [4:0]  gctl_req, gctl_eff;
  logic [17:0] fmt_q;
  logic [15:0] frm_q;
  logic [7:0]  clk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gctl_req <= '0;
      gctl_eff <= '0;
      fmt_q    <= '0;
      frm_q    <= '0;
      clk_q    <= '0;
      keep     <= '1;
      slot_en  <= '0;
    end else begin
      gctl_eff <= gctl_req;
      if (we) begin
        case (addr)
          A_GCTL: gctl_req <= wdata[12:8];
          A_FMT:  fmt_q    <= wdata[17:0];
          A_FRM:  frm_q    <= wdata[15:0];
          A_CLK:  clk_q    <= wdata[7:0];
          A_KEEP: keep     <= wdata;
          A_SLOT: slot_en  <= wdata;
          default: ;
        endcase
      end
    end
  end

  assign buf_wr   = we && (addr == A_BUF);
  assign undr_clr = we && (addr == A_STAT) && wdata[0];

  assign f_rot    = fmt_q[2:0];
  assign f_ssz    = fmt_q[7:4];
  assign f_pidx   = fmt_q[12:8];
  assign f_pad    = fmt_q[14:13];
  assign f_msb    = fmt_q[15];
  assign f_dly    = fmt_q[17:16];
  assign fr_pol   = frm_q[0];
  assign fr_int   = frm_q[1];
  assign fr_wide  = frm_q[4];
  assign fr_nslot = frm_q[15:7];
  assign ck_div   = clk_q[DIV_W-1:0];
  assign ck_int   = clk_q[5];
  assign ck_fall  = clk_q[7];
  assign g_bclk   = gctl_eff[0];
  assign g_ser    = gctl_eff[2];
  assign g_sm     = gctl_eff[3];
  assign g_fsg    = gctl_eff[4];

  always_comb begin
    case (addr)
      A_GCTL:  rdata = {19'b0, gctl_eff, 8'b0};
      A_FMT:   rdata = {14'b0, fmt_q};
      A_FRM:   rdata = {16'b0, frm_q};
      A_CLK:   rdata = {24'b0, clk_q};
      A_KEEP:  rdata = keep;
      A_SLOT:  rdata = slot_en;
      A_BUF:   rdata = buf_q;
      default: rdata = {27'b0, ready, 3'b0, undr};
    endcase
  end

endmodule

// File: rtl/tdm_tx_clkgen.sv
module tdm_tx_clkgen #(
  parameter int unsigned DIV_W       = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             int_src,
  input  logic             fall,
  input  logic [DIV_W-1:0] div,
  input  logic             ext_bclk,
  output logic             stp
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [DIV_W-1:0]       cnt_q;
  logic                   tick, edge_hit, sync_lvl;

  assign sync_lvl = sync_q[SYNC_STAGES-1];

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= ext_bclk;
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], ext_bclk};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= sync_lvl;
      if (!run || !int_src || tick) cnt_q <= '0;
      else                          cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  assign tick     = cnt_q >= div;
  assign edge_hit = fall ? (prev_q && !sync_lvl) : (!prev_q && sync_lvl);
  assign stp      = run && (int_src ? tick : edge_hit);

endmodule

// File: rtl/tdm_tx_framer.sv
module tdm_tx_framer
  import tdm_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stp,
  input  logic             run,
  input  logic             fs_on,
  input  logic             fs_int,
  input  logic             pol,
  input  logic             wide,
  input  logic [POS_W-1:0] sbits,
  input  logic [POS_W-1:0] nslots,
  input  logic [1:0]       dly,
  output logic             fs_o,
  output logic             slot_start,
  output logic [4:0]       dslot,
  output logic [POS_W-1:0] dbit
);
  pos_t fpos, dpos, dinit;
  logic [1:0] dl;
  logic fs_act;

  always_comb begin
    dl = (dly == 2'd3) ? 2'd2 : dly;
    if (dl == 2'd0) begin
      dinit = '0;
    end else begin
      dinit.bitc = sbits - {{(POS_W-2){1'b0}}, dl};
      dinit.slot = nslots - POS_W'(1);
    end
  end

  assign fs_act = (fpos.slot == '0) && (wide || (fpos.bitc == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fpos <= '0;
      dpos <= '0;
      fs_o <= 1'b0;
    end else begin
      if (!run) begin
        fpos <= '0;
        dpos <= dinit;
      end else if (stp) begin
        fpos <= adv(fpos, sbits, nslots);
        dpos <= adv(dpos, sbits, nslots);
      end
      if (!fs_int)              fs_o <= 1'b0;
      else if (!(fs_on && run)) fs_o <= pol;
      else if (stp)             fs_o <= pol ^ fs_act;
    end
  end

  assign slot_start = stp && run && (dpos.bitc == '0);
  assign dslot      = dpos.slot[4:0];
  assign dbit       = dpos.bitc;

  // R9
  fs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_int && !fs_on) |=> (fs_o == $past(pol)));

  // R11
  fs_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_int |=> !fs_o);

endmodule

// File: rtl/tdm_tx_serdata.sv
module tdm_tx_serdata
  import tdm_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_en,
  input  logic              run,
  input  logic              stp,
  input  logic              slot_start,
  input  logic [4:0]        dslot,
  input  logic [POS_W-1:0]  dbit,
  input  logic [WORD_W-1:0] slot_en,
  input  logic [WORD_W-1:0] keep,
  input  logic [2:0]        rot,
  input  logic [1:0]        pad,
  input  logic [4:0]        pidx,
  input  logic              msb,
  input  logic [POS_W-1:0]  sbits,
  input  logic              buf_wr,
  input  logic [WORD_W-1:0] buf_wdata,
  input  logic              undr_clr,
  output logic [WORD_W-1:0] buf_q,
  output logic              ready,
  output logic              undr,
  output logic              ser_o
);
  logic              full, act, en_now, nbit;
  logic [WORD_W-1:0] cur, nword;

  assign en_now = slot_en[dslot];
  assign nword  = (en_now && full) ? fmt_word(buf_q, rot, keep, pad, pidx) : '0;
  assign nbit   = slot_start ? (en_now && pick_bit(nword, sbits, '0, msb))
                             : (act && pick_bit(cur, sbits, dbit, msb));
  assign ready  = ser_en && !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      full  <= 1'b0;
      undr  <= 1'b0;
      cur   <= '0;
      act   <= 1'b0;
      ser_o <= 1'b0;
    end else begin
      if (buf_wr) buf_q <= buf_wdata;
      if (!ser_en)                    full <= 1'b0;
      else if (buf_wr)                full <= 1'b1;
      else if (slot_start && en_now)  full <= 1'b0;
      if (slot_start && en_now && !full) undr <= 1'b1;
      else if (undr_clr)                 undr <= 1'b0;
      if (!run) begin
        act <= 1'b0;
        cur <= '0;
      end else if (slot_start) begin
        act <= en_now;
        cur <= nword;
      end
      if (!ser_en || !run) ser_o <= 1'b0;
      else if (stp)        ser_o <= nbit;
    end
  end

  // R7
  inact_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_start && !en_now) |=> !ser_o);

  // R10
  undr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(undr) |-> $past(slot_start && en_now && !full));

  // R10
  wr_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_wr && ser_en) |=> !ready);

endmodule

// File: rtl/tdm_tx.sv
module tdm_tx
  import tdm_tx_pkg::*;
#(
  parameter int unsigned DIV_W       = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        ext_bclk,
  output logic        ser_o,
  output logic        fs_o
);
  logic [2:0]        f_rot;
  logic [3:0]        f_ssz;
  logic [4:0]        f_pidx;
  logic [1:0]        f_pad, f_dly;
  logic              f_msb, fr_pol, fr_int, fr_wide, ck_int, ck_fall;
  logic [8:0]        fr_nslot;
  logic [DIV_W-1:0]  ck_div;
  logic [WORD_W-1:0] keep, slot_en, buf_q;
  logic              g_bclk, g_ser, g_sm, g_fsg, buf_wr, undr_clr, ready, undr;
  logic              stp, slot_start;
  logic [4:0]        dslot;
  logic [POS_W-1:0]  dbit, sbits, nslots;

  assign sbits  = slot_bits(f_ssz);
  assign nslots = clamp_slots(fr_nslot);

  tdm_tx_regs #(.DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .f_rot(f_rot), .f_ssz(f_ssz), .f_pidx(f_pidx), .f_pad(f_pad),
    .f_msb(f_msb), .f_dly(f_dly), .fr_pol(fr_pol), .fr_int(fr_int), .fr_wide(fr_wide),
    .fr_nslot(fr_nslot), .ck_div(ck_div), .ck_int(ck_int), .ck_fall(ck_fall),
    .keep(keep), .slot_en(slot_en), .g_bclk(g_bclk), .g_ser(g_ser), .g_sm(g_sm),
    .g_fsg(g_fsg), .buf_wr(buf_wr), .undr_clr(undr_clr), .ready(ready), .undr(undr),
    .buf_q(buf_q)
  );

  tdm_tx_clkgen #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(g_bclk), .int_src(ck_int), .fall(ck_fall),
    .div(ck_div), .ext_bclk(ext_bclk), .stp(stp)
  );

  tdm_tx_framer u_frm (
    .clk(clk), .rst_n(rst_n), .stp(stp), .run(g_sm), .fs_on(g_fsg), .fs_int(fr_int),
    .pol(fr_pol), .wide(fr_wide), .sbits(sbits), .nslots(nslots), .dly(f_dly),
    .fs_o(fs_o), .slot_start(slot_start), .dslot(dslot), .dbit(dbit)
  );

  tdm_tx_serdata u_ser (
    .clk(clk), .rst_n(rst_n), .ser_en(g_ser), .run(g_sm), .stp(stp),
    .slot_start(slot_start), .dslot(dslot), .dbit(dbit), .slot_en(slot_en),
    .keep(keep), .rot(f_rot), .pad(f_pad), .pidx(f_pidx), .msb(f_msb), .sbits(sbits),
    .buf_wr(buf_wr), .buf_wdata(cfg_wdata), .undr_clr(undr_clr), .buf_q(buf_q),
    .ready(ready), .undr(undr), .ser_o(ser_o)
  );

  // R9
  ser_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !g_ser |=> !ser_o);

endmodule

// File: tb/tb_tdm_tx.sv
module tb_tdm_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        ext_bclk = 1'b0;
  logic        ser_o, fs_o;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  // model configuration
  int c_S, c_N, c_dly, c_rot, c_pbit, c_pad;
  bit c_msb, c_wide, c_pol, c_fsint, c_fall;
  logic [31:0] c_mask, c_en;
  logic [31:0] wq [8];
  int wn;

  tdm_tx dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ext_bclk(ext_bclk),
    .ser_o(ser_o), .fs_o(fs_o)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic bit_step();
    ext_bclk = 1'b1;
    repeat (6) @(negedge clk);
    ext_bclk = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  function automatic logic [31:0] tb_fmt(input logic [31:0] w);
    logic [31:0] r, o;
    logic pb;
    for (int i = 0; i < 32; i++) r[i] = w[(i + 4 * c_rot) % 32];
    pb = (c_pad >= 2) ? r[c_pbit] : (c_pad == 1);
    for (int i = 0; i < 32; i++) o[i] = c_mask[i] ? r[i] : pb;
    return o;
  endfunction

  function automatic logic exp_ser(input int t);
    int d, k, b, sl, idx;
    logic [31:0] fw;
    d = t - c_dly;
    if (d < 0) return 1'b0;
    k = d / c_S; b = d % c_S; sl = k % c_N;
    if (!c_en[sl]) return 1'b0;
    idx = 0;
    for (int j = 0; j < k; j++) if (c_en[j % c_N]) idx++;
    if (idx >= wn) return 1'b0;
    fw = tb_fmt(wq[idx]);
    return c_msb ? fw[c_S - 1 - b] : fw[b];
  endfunction

  function automatic logic exp_fs(input int t);
    int pos;
    pos = t % (c_S * c_N);
    if (!c_fsint) return 1'b0;
    return ((pos < (c_wide ? c_S : 1)) ? 1'b1 : 1'b0) ^ c_pol;
  endfunction

  task automatic setup_run(input int code, input int nfield, input int dfield,
                           input logic [7:0] clkc);
    logic [31:0] fmtw, frmw, rb;
    fmtw = c_rot | (code << 4) | (c_pbit << 8) | (c_pad << 13) | (c_msb << 15) | (dfield << 16);
    frmw = c_pol | (c_fsint << 1) | (c_wide << 4) | (nfield << 7);
    wr(3'd0, 32'h0);
    wr(3'd1, fmtw);
    wr(3'd2, frmw);
    wr(3'd3, {24'b0, clkc});
    wr(3'd4, c_mask);
    wr(3'd5, c_en);
    rd(3'd1, rb);
    chk(rb == fmtw, "R12", "format readback", rb, fmtw);
    wr(3'd0, 32'h100);
    wr(3'd0, 32'h500);
    @(negedge clk);
  endtask

  task automatic run_stream(input string tag, input int code, input int nfield,
                            input int dfield, input int nsteps);
    int widx, sbad, fbad;
    logic [31:0] st;
    logic fa, fe, sa, se;
    setup_run(code, nfield, dfield, {c_fall, 1'b0, 1'b0, 5'd0});
    wr(3'd6, wq[0]);
    widx = 1;
    wr(3'd0, 32'h1F00);
    @(negedge clk); @(negedge clk);
    sbad = 0; fbad = 0; fa = 0; fe = 0; sa = 0; se = 0;
    for (int t = 0; t < nsteps; t++) begin
      bit_step();
      if (ser_o !== exp_ser(t)) begin
        if (sbad == 0) begin sa = ser_o; se = exp_ser(t); end
        sbad++;
      end
      if (fs_o !== exp_fs(t)) begin
        if (fbad == 0) begin fa = fs_o; fe = exp_fs(t); end
        fbad++;
      end
      rd(3'd7, st);
      if (st[4] && widx < wn) begin
        wr(3'd6, wq[widx]);
        widx++;
      end
    end
    chk(sbad == 0, tag, "serial data stream", {31'b0, sa}, {31'b0, se});
    chk(fbad == 0, "R5/R11", {tag, " frame sync"}, {31'b0, fa}, {31'b0, fe});
  endtask

  // R1 R4 R2: 16-bit slots, MSB first, 16-bit rotation
  task automatic test_basic();
    logic [31:0] st;
    c_S = 16; c_N = 2; c_dly = 0; c_rot = 4; c_pbit = 0; c_pad = 0;
    c_msb = 1; c_wide = 0; c_pol = 0; c_fsint = 1; c_fall = 0;
    c_mask = 32'h0000FFFF; c_en = 32'hFFFFFFFF;
    wq[0] = 32'h1234ABCD; wq[1] = 32'hBEEF0001; wq[2] = 32'h8001F0F0;
    wq[3] = 32'h0F0F5555; wq[4] = 32'hC3A50000; wq[5] = 32'h7E817E81;
    wn = 6;
    run_stream("R1/R2/R4", 7, 2, 0, 96);
    rd(3'd7, st);
    chk(st[0] == 1'b0, "R10", "no underrun when fed", st, 32'h0);
  endtask

  // R3 R4 R6 R7 R8: 24-bit LSB first, pad ones, delay 1, wide inverted fs, falling edge
  task automatic test_lsb_gap();
    logic [31:0] rb;
    c_S = 24; c_N = 4; c_dly = 1; c_rot = 0; c_pbit = 0; c_pad = 1;
    c_msb = 0; c_wide = 1; c_pol = 1; c_fsint = 1; c_fall = 1;
    c_mask = 32'h00FFFFFF; c_en = 32'h0000000B;
    wq[0] = 32'h00A1B2C3; wq[1] = 32'h12800001; wq[2] = 32'h00FFFF00;
    wq[3] = 32'h00123456; wq[4] = 32'hFF0F0F0F; wq[5] = 32'h00654321;
    wn = 6;
    run_stream("R3/R4/R6/R7/R8", 11, 4, 1, 192);
    // R9: stop with global control 0
    wr(3'd0, 32'h0);
    @(negedge clk); @(negedge clk);
    rd(3'd0, rb);
    chk(rb == 32'h0, "R9", "global readback after stop", rb, 32'h0);
    bit_step();
    chk(fs_o == 1'b1, "R9", "fs at inactive level after stop", {31'b0, fs_o}, 32'h1);
    chk(ser_o == 1'b0, "R9", "pin low after stop", {31'b0, ser_o}, 32'h0);
    rd(3'd7, rb);
    chk(rb[4] == 1'b0, "R10", "not ready while serializer held", rb, 32'h0);
  endtask

  // R1 R2 R3 R6 R11: even code 4 (12 bits), 24-bit rotation, sign pad, delay code 3, fs low
  task automatic test_pad_copy();
    c_S = 12; c_N = 3; c_dly = 2; c_rot = 6; c_pbit = 7; c_pad = 2;
    c_msb = 1; c_wide = 0; c_pol = 0; c_fsint = 0; c_fall = 0;
    c_mask = 32'h000000FF; c_en = 32'hFFFFFFFF;
    wq[0] = 32'hA5000000; wq[1] = 32'h5A000000; wq[2] = 32'h80123456;
    wq[3] = 32'h7F000000; wq[4] = 32'hC0000001; wq[5] = 32'h01FFFFFF;
    wn = 6;
    run_stream("R1/R2/R3/R6", 4, 3, 3, 72);
  endtask

  // R10 R5: single word then underrun, slot field 1 acts as 2
  task automatic test_underrun();
    logic [31:0] st;
    c_S = 8; c_N = 2; c_dly = 0; c_rot = 0; c_pbit = 0; c_pad = 0;
    c_msb = 1; c_wide = 0; c_pol = 0; c_fsint = 1; c_fall = 0;
    c_mask = 32'h000000FF; c_en = 32'hFFFFFFFF;
    wq[0] = 32'h000000C3;
    wn = 1;
    run_stream("R10/R5", 3, 1, 0, 32);
    rd(3'd7, st);
    chk(st[0] == 1'b1, "R10", "underrun flag set", st, 32'h1);
    wr(3'd7, 32'h1);
    rd(3'd7, st);
    chk(st[0] == 1'b0, "R10", "underrun flag cleared", st, 32'h0);
  endtask

  // R8: internal divider, div=3, 2 slots of 8 bits
  task automatic test_divider();
    int hi, per, guard;
    c_rot = 0; c_pbit = 0; c_pad = 0; c_msb = 1; c_wide = 0; c_pol = 0;
    c_fsint = 1; c_fall = 0; c_mask = 32'hFF; c_en = 32'hFFFFFFFF;
    setup_run(3, 2, 0, 8'h23);
    wr(3'd0, 32'h1F00);
    guard = 0;
    while (fs_o == 1'b0 && guard < 500) begin @(negedge clk); guard++; end
    hi = 0; per = 0;
    while (fs_o == 1'b1 && hi < 500) begin @(negedge clk); hi++; per++; end
    while (fs_o == 1'b0 && per < 500) begin @(negedge clk); per++; end
    chk(hi == 4, "R8", "divided fs high clocks", hi, 4);
    chk(per == 64, "R8", "divided frame period clocks", per, 64);
    wr(3'd0, 32'h0);
  endtask

  initial begin : main
    logic [31:0] rb;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ser_o == 1'b0, "R9", "reset pin level", {31'b0, ser_o}, 32'h0);
    chk(fs_o == 1'b0, "R9", "reset fs level", {31'b0, fs_o}, 32'h0);
    rd(3'd0, rb);
    chk(rb == 32'h0, "R9", "reset global readback", rb, 32'h0);
    rd(3'd7, rb);
    chk(rb == 32'h0, "R10", "reset status", rb, 32'h0);
    test_basic();
    test_lsb_gap();
    test_pad_copy();
    test_underrun();
    test_divider();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog all act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

endmodule